// File: doc/BRIEF.md
# Full-Speed Bus Line-State and Suspend Monitor

This block sits behind the receivers of a full-speed serial bus device port. On each bit-rate sample enable it registers the two single-ended line levels and sorts them into four line conditions: idle (J), the opposite polarity (K), both lines low (SE0), and the illegal both-high case. A low-speed select input swaps which polarity counts as idle. From the sampled conditions and cycle counters on the free-running system clock, it reports packet start, packet end, bus reset, entry into the low-power suspended state and wake-up.

Packet start and packet end are found from line-level timing alone, not from decoded packet contents. A long SE0 is a bus reset and not a packet end. Continuous idle puts the port into suspend. Any non-idle level while suspended brings it back. After a minimum stay in suspend, a local wake request makes the block drive K for a fixed time, then leave suspend on its own. All time constants are parameters in microseconds or nanoseconds and are turned into clock cycles from the clock frequency.

Top module: `usb_line_monitor`

## Requirements
- R1: `lineState` reports the most recently sampled line condition with encoding 0 = both low (SE0), 1 = J, 2 = K, 3 = both high. With `lowSpeed` = 0, J is `lineDp`=1/`lineDm`=0 and K is `lineDp`=0/`lineDm`=1. With `lowSpeed` = 1, those two assignments swap.
- R2: `sopPulse` is high for one cycle when a K sample directly follows a J sample while no packet is open. K samples after that within the same packet give no further pulse. Any SE0 sample closes the packet.
- R3: When an SE0 run of 1 to 3 consecutive samples ends, `eopPulse` is high for one cycle. A run of 4 or more samples gives no `eopPulse`.
- R4: An SE0 held for the reset time (default 2.5 us) gives exactly one single-cycle `resetPulse` for that run. The run then gives no `eopPulse`.
- R5: `suspended` rises after the line has been J without a break for the suspend time (default 3 ms). Any non-J sample restarts that count.
- R6: While suspended and not driving wake-up, any non-J sample clears `suspended` and gives a one-cycle `resumePulse`, without a `sopPulse`.
- R7: `wakeReq` is sampled each cycle and is not stored. It is ignored when the port is not suspended, and ignored until the port has been suspended for the minimum time (default 5 ms).
- R8: An accepted wake request holds `wakeDrive` high for exactly the drive time (default 10 ms) in cycles, with `suspended` still high. In the cycle after the drive ends, `suspended` is low and `resumePulse` fires.
- R9: After reset every pulse output, `suspended` and `wakeDrive` are 0. Every pulse output is high for one cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock, frequency given by `CLK_HZ` |
| rstN | input | 1 | Active-low synchronous reset |
| sampleEn | input | 1 | One-cycle bit-rate strobe; line levels are captured on it |
| lineDp | input | 1 | Single-ended receiver output of the positive data line |
| lineDm | input | 1 | Single-ended receiver output of the negative data line |
| lowSpeed | input | 1 | 1 swaps J/K polarity for a low-speed port |
| wakeReq | input | 1 | Request to drive remote wake-up signalling |
| lineState | output | 2 | Sampled line condition (see R1) |
| sopPulse | output | 1 | Packet-start pulse |
| eopPulse | output | 1 | Packet-end pulse |
| resetPulse | output | 1 | Bus-reset pulse |
| suspended | output | 1 | Suspended level |
| resumePulse | output | 1 | Pulse on leaving suspend |
| wakeDrive | output | 1 | High while K must be driven for wake-up |

## Verification
The bench tests the SE0 length boundary by sending runs of 3 and of 4 samples. A design with an off-by-one threshold would report a packet end for the 4-sample run or miss the 3-sample one. A long SE0 must give exactly one reset and no packet end, so a design that also flagged the run as a packet end at release would show up. The idle count is broken by a single SE0 bit partway through; a design that paused instead of restarting the count would suspend too early. On the wake-up side, the bench sends one request too early and one while active, both of which must leave `wakeDrive` low, and it counts the drive window cycle by cycle. It also checks that resume K levels do not appear as packet starts.

// File: rtl/usb_lm_pkg.sv
package usb_lm_pkg;

  typedef enum logic [1:0] {
    LS_SE0 = 2'd0,
    LS_J   = 2'd1,
    LS_K   = 2'd2,
    LS_SE1 = 2'd3
  } lineSt_t;

  // control -> datapath
  typedef struct packed {
    logic clrIdle;
    logic runSusp;
    logic runDrive;
  } ctlStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic jToK;
    logic se0Now;
    logic se0End;
    logic se0Long;
    logic idleDone;
    logic nonJ;
    logic wakeOk;
    logic driveDone;
  } dpFlag_t;

  function automatic lineSt_t classifyLine(input logic dp, input logic dm, input logic lowSpd);
    lineSt_t res;
    case ({dp, dm})
      2'b00:   res = LS_SE0;
      2'b11:   res = LS_SE1;
      2'b10:   res = lowSpd ? LS_K : LS_J;
      default: res = lowSpd ? LS_J : LS_K;
    endcase
    return res;
  endfunction

  function automatic int usToCycles(input int clkHz, input int us);
    return (clkHz / 1000) * us / 1000;
  endfunction

  function automatic int nsToCycles(input int clkHz, input int ns);
    return (clkHz / 1000) * ns / 1000000;
  endfunction

endpackage

// File: rtl/usb_lm_datapath.sv
module usb_lm_datapath
  import usb_lm_pkg::*;
#(
  parameter int SUSP_CYC  = 144000,
  parameter int RESET_CYC = 120,
  parameter int WMIN_CYC  = 240000,
  parameter int DRIVE_CYC = 480000,
  parameter int EOP_MAX   = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sampleEn,
  input  logic       lineDp,
  input  logic       lineDm,
  input  logic       lowSpeed,
  input  ctlStrobe_t ctl,
  output dpFlag_t    flags,
  output logic [1:0] lineState
);

  localparam int SW = $clog2(SUSP_CYC + 1);
  localparam int RW = $clog2(RESET_CYC + 1);
  localparam int WW = $clog2(WMIN_CYC + 1);
  localparam int DW = $clog2(DRIVE_CYC + 1);
  localparam int BW = $clog2(EOP_MAX + 1);
  localparam logic [SW-1:0] SUSP_MAX  = SW'(SUSP_CYC);
  localparam logic [RW-1:0] RESET_MAX = RW'(RESET_CYC);
  localparam logic [WW-1:0] WMIN_MAX  = WW'(WMIN_CYC);
  localparam logic [DW-1:0] DRIVE_END = DW'(DRIVE_CYC - 1);
  localparam logic [BW-1:0] BITS_MAX  = BW'(EOP_MAX);

  lineSt_t lineSt, prevSt;
  logic    sampleVld;
  logic [BW-1:0] se0Bits;
  logic [RW-1:0] se0Cyc;
  logic [SW-1:0] idleCnt;
  logic [WW-1:0] suspCnt;
  logic [DW-1:0] driveCnt;

  // line sampler: two most recent samples plus a valid strobe
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineSt    <= LS_SE0;
      prevSt    <= LS_SE0;
      sampleVld <= 1'b0;
    end else begin
      sampleVld <= sampleEn;
      if (sampleEn) begin
        prevSt <= lineSt;
        lineSt <= classifyLine(lineDp, lineDm, lowSpeed);
      end
    end
  end

  // SE0 run length in samples and in clock cycles
  always_ff @(posedge clk) begin
    if (!rstN) begin
      se0Bits <= '0;
      se0Cyc  <= '0;
    end else begin
      if (sampleVld) begin
        if (lineSt != LS_SE0) se0Bits <= '0;
        else if (se0Bits != BITS_MAX) se0Bits <= se0Bits + 1'b1;
      end
      if (lineSt != LS_SE0) se0Cyc <= '0;
      else if (se0Cyc != RESET_MAX) se0Cyc <= se0Cyc + 1'b1;
    end
  end

  // idle, suspend-age and wake-drive counters
  always_ff @(posedge clk) begin
    if (!rstN) begin
      idleCnt  <= '0;
      suspCnt  <= '0;
      driveCnt <= '0;
    end else begin
      if (ctl.clrIdle || lineSt != LS_J) idleCnt <= '0;
      else if (idleCnt != SUSP_MAX) idleCnt <= idleCnt + 1'b1;

      if (!ctl.runSusp) suspCnt <= '0;
      else if (suspCnt != WMIN_MAX) suspCnt <= suspCnt + 1'b1;

      if (!ctl.runDrive) driveCnt <= '0;
      else driveCnt <= driveCnt + 1'b1;
    end
  end

  always_comb begin
    flags.jToK      = sampleVld && prevSt == LS_J && lineSt == LS_K;
    flags.se0Now    = lineSt == LS_SE0;
    flags.se0End    = sampleVld && prevSt == LS_SE0 && lineSt != LS_SE0 &&
                      se0Bits != '0 && se0Bits < BITS_MAX && se0Cyc != RESET_MAX;
    flags.se0Long   = lineSt == LS_SE0 && se0Cyc == RESET_MAX - 1'b1;
    flags.idleDone  = idleCnt == SUSP_MAX;
    flags.nonJ      = lineSt != LS_J;
    flags.wakeOk    = suspCnt == WMIN_MAX;
    flags.driveDone = driveCnt == DRIVE_END;
  end

  assign lineState = lineSt;

endmodule

// File: rtl/usb_lm_control.sv
module usb_lm_control
  import usb_lm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  dpFlag_t    flags,
  input  logic       wakeReq,
  output ctlStrobe_t ctl,
  output logic       sopPulse,
  output logic       eopPulse,
  output logic       resetPulse,
  output logic       resumePulse,
  output logic       suspended,
  output logic       wakeDrive
);

  typedef enum logic [1:0] {ST_ACTIVE, ST_SUSP, ST_WAKE} ctlSt_t;

  ctlSt_t state;
  logic   inPacket;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= ST_ACTIVE;
      inPacket    <= 1'b0;
      sopPulse    <= 1'b0;
      eopPulse    <= 1'b0;
      resetPulse  <= 1'b0;
      resumePulse <= 1'b0;
    end else begin
      sopPulse    <= 1'b0;
      eopPulse    <= 1'b0;
      resetPulse  <= 1'b0;
      resumePulse <= 1'b0;
      case (state)
        ST_ACTIVE: begin
          if (flags.se0Now) inPacket <= 1'b0;
          if (flags.se0Long) resetPulse <= 1'b1;
          if (flags.se0End) eopPulse <= 1'b1;
          if (flags.jToK && !inPacket) begin
            sopPulse <= 1'b1;
            inPacket <= 1'b1;
          end
          if (flags.idleDone) state <= ST_SUSP;
        end
        ST_SUSP: begin
          inPacket <= 1'b0;
          if (flags.nonJ) begin
            state       <= ST_ACTIVE;
            resumePulse <= 1'b1;
          end else if (wakeReq && flags.wakeOk) begin
            state <= ST_WAKE;
          end
        end
        ST_WAKE: begin
          if (flags.driveDone) begin
            state       <= ST_ACTIVE;
            resumePulse <= 1'b1;
          end
        end
        default: state <= ST_ACTIVE;
      endcase
    end
  end

  always_comb begin
    ctl.clrIdle  = state != ST_ACTIVE;
    ctl.runSusp  = state == ST_SUSP;
    ctl.runDrive = state == ST_WAKE;
  end

  assign suspended = state != ST_ACTIVE;
  assign wakeDrive = state == ST_WAKE;

endmodule

// File: rtl/usb_line_monitor.sv
module usb_line_monitor
  import usb_lm_pkg::*;
#(
  parameter int CLK_HZ        = 48000000,
  parameter int SUSPEND_US    = 3000,
  parameter int RESET_NS      = 2500,
  parameter int WAKE_MIN_US   = 5000,
  parameter int WAKE_DRIVE_US = 10000,
  parameter int EOP_MAX_BITS  = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sampleEn,
  input  logic       lineDp,
  input  logic       lineDm,
  input  logic       lowSpeed,
  input  logic       wakeReq,
  output logic [1:0] lineState,
  output logic       sopPulse,
  output logic       eopPulse,
  output logic       resetPulse,
  output logic       suspended,
  output logic       resumePulse,
  output logic       wakeDrive
);

  localparam int SUSP_CYC  = usToCycles(CLK_HZ, SUSPEND_US);
  localparam int RESET_CYC = nsToCycles(CLK_HZ, RESET_NS);
  localparam int WMIN_CYC  = usToCycles(CLK_HZ, WAKE_MIN_US);
  localparam int DRIVE_CYC = usToCycles(CLK_HZ, WAKE_DRIVE_US);

  ctlStrobe_t ctl;
  dpFlag_t    flags;

  usb_lm_datapath #(
    .SUSP_CYC (SUSP_CYC),
    .RESET_CYC(RESET_CYC),
    .WMIN_CYC (WMIN_CYC),
    .DRIVE_CYC(DRIVE_CYC),
    .EOP_MAX  (EOP_MAX_BITS)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .sampleEn (sampleEn),
    .lineDp   (lineDp),
    .lineDm   (lineDm),
    .lowSpeed (lowSpeed),
    .ctl      (ctl),
    .flags    (flags),
    .lineState(lineState)
  );

  usb_lm_control u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .flags      (flags),
    .wakeReq    (wakeReq),
    .ctl        (ctl),
    .sopPulse   (sopPulse),
    .eopPulse   (eopPulse),
    .resetPulse (resetPulse),
    .resumePulse(resumePulse),
    .suspended  (suspended),
    .wakeDrive  (wakeDrive)
  );

endmodule

// File: rtl/usb_line_monitor_chk.sv
module usb_line_monitor_chk (
  input logic       clk,
  input logic       rstN,
  input logic       wakeReq,
  input logic [1:0] lineState,
  input logic       sopPulse,
  input logic       eopPulse,
  input logic       resetPulse,
  input logic       suspended,
  input logic       resumePulse,
  input logic       wakeDrive
);

  assert_no_sop_in_suspend_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(suspended && sopPulse));

  assert_reset_not_eop_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(eopPulse && resetPulse));

  assert_suspend_after_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(suspended) |-> $past(lineState) == 2'd1);

  assert_resume_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
    resumePulse |-> !suspended);

  assert_wake_needs_request_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wakeDrive) |-> $past(suspended) && $past(wakeReq));

  assert_drive_inside_suspend_R8: assert property (@(posedge clk) disable iff (!rstN)
    wakeDrive |-> suspended);

  assert_drive_end_resumes_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wakeDrive) |-> resumePulse && !suspended);

  assert_eop_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    eopPulse |=> !eopPulse);

  assert_reset_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    resetPulse |=> !resetPulse);

  assert_sop_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    sopPulse |=> !sopPulse);

endmodule

bind usb_line_monitor usb_line_monitor_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .wakeReq    (wakeReq),
  .lineState  (lineState),
  .sopPulse   (sopPulse),
  .eopPulse   (eopPulse),
  .resetPulse (resetPulse),
  .suspended  (suspended),
  .resumePulse(resumePulse),
  .wakeDrive  (wakeDrive)
);

// File: tb/usb_line_monitor_bench.sv
module usb_line_monitor_bench;

  localparam int CLK_HZ   = 100000000;
  localparam int SUSP_US  = 20;   // 2000 cycles
  localparam int RST_NS   = 2500; // 250 cycles
  localparam int WMIN_US  = 30;   // 3000 cycles
  localparam int DRIVE_US = 10;   // 1000 cycles
  localparam int DRIVE_CYC = DRIVE_US * 100;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleEn = 1'b0;
  logic lineDp = 1'b1;
  logic lineDm = 1'b0;
  logic lowSpeed = 1'b0;
  logic wakeReq = 1'b0;
  logic [1:0] lineState;
  logic sopPulse, eopPulse, resetPulse, suspended, resumePulse, wakeDrive;

  int checks = 0;
  int fails = 0;
  int nSop = 0, nEop = 0, nRst = 0, nRes = 0, nDrive = 0;
  logic [2:0] divCnt = '0;
  bit finished = 0;

  always #5 clk = ~clk;

  // bit-rate strobe: one cycle in eight
  always @(posedge clk) begin
    divCnt   <= divCnt + 3'd1;
    sampleEn <= (divCnt == 3'd7);
  end

  always @(negedge clk) begin
    if (rstN) begin
      if (sopPulse)    nSop++;
      if (eopPulse)    nEop++;
      if (resetPulse)  nRst++;
      if (resumePulse) nRes++;
      if (wakeDrive)   nDrive++;
    end
  end

  usb_line_monitor #(
    .CLK_HZ(CLK_HZ), .SUSPEND_US(SUSP_US), .RESET_NS(RST_NS),
    .WAKE_MIN_US(WMIN_US), .WAKE_DRIVE_US(DRIVE_US), .EOP_MAX_BITS(4)
  ) u_usb_line_monitor (
    .clk(clk), .rstN(rstN), .sampleEn(sampleEn), .lineDp(lineDp), .lineDm(lineDm),
    .lowSpeed(lowSpeed), .wakeReq(wakeReq), .lineState(lineState),
    .sopPulse(sopPulse), .eopPulse(eopPulse), .resetPulse(resetPulse),
    .suspended(suspended), .resumePulse(resumePulse), .wakeDrive(wakeDrive)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // hold a line level for exactly n sample strobes
  task automatic drive(input logic dp, input logic dm, input int n);
    int k = 0;
    lineDp = dp;
    lineDm = dm;
    while (k < n) begin
      if (sampleEn) k++;
      @(negedge clk);
    end
  endtask

  task automatic idleJ(input int n); drive(1'b1, 1'b0, n); endtask
  task automatic sendK(input int n); drive(1'b0, 1'b1, n); endtask
  task automatic sendSe0(input int n); drive(1'b0, 1'b0, n); endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitSuspend();
    for (int i = 0; i < 2600 && !suspended; i++) @(negedge clk);
  endtask

  task automatic pulseWake();
    wakeReq = 1'b1;
    @(negedge clk);
    wakeReq = 1'b0;
  endtask

  task automatic testResetState();
    check("R9 sop after reset", int'(sopPulse), 0);
    check("R9 eop after reset", int'(eopPulse), 0);
    check("R9 resetPulse after reset", int'(resetPulse), 0);
    check("R9 suspended after reset", int'(suspended), 0);
    check("R9 wakeDrive after reset", int'(wakeDrive), 0);
  endtask

  task automatic testClassify();
    drive(1'b1, 1'b0, 2); check("R1 full-speed J", int'(lineState), 1);
    drive(1'b0, 1'b1, 2); check("R1 full-speed K", int'(lineState), 2);
    drive(1'b0, 1'b0, 2); check("R1 SE0", int'(lineState), 0);
    drive(1'b1, 1'b1, 2); check("R1 both high", int'(lineState), 3);
    lowSpeed = 1'b1;
    drive(1'b1, 1'b0, 2); check("R1 low-speed swap dp high", int'(lineState), 2);
    drive(1'b0, 1'b1, 2); check("R1 low-speed swap dm high", int'(lineState), 1);
    lowSpeed = 1'b0;
    idleJ(4);
  endtask

  task automatic testPackets();
    int s0 = nSop, e0 = nEop;
    idleJ(3); sendK(1); idleJ(1); sendK(1); idleJ(1); sendK(2);
    sendSe0(2); idleJ(3);
    check("R2 one sop per packet", nSop - s0, 1);
    check("R3 eop for 2-sample SE0", nEop - e0, 1);
    sendK(1); idleJ(2); sendK(1); sendSe0(3); idleJ(3);
    check("R2 sop after packet closed", nSop - s0, 2);
    check("R3 eop for 3-sample SE0", nEop - e0, 2);
    sendK(2); sendSe0(4); idleJ(3);
    check("R3 no eop for 4-sample SE0", nEop - e0, 2);
  endtask

  task automatic testBusReset();
    int e0 = nEop, r0 = nRst;
    sendSe0(5); idleJ(2);
    check("R4 short SE0 is no reset", nRst - r0, 0);
    sendSe0(40); idleJ(2);
    check("R4 single reset pulse", nRst - r0, 1);
    check("R4 no eop for reset run", nEop - e0, 0);
  endtask

  task automatic testSuspend();
    idleJ(2);
    waitCycles(1500);
    sendSe0(1); idleJ(1);
    waitCycles(1500);
    check("R5 idle count restarted by SE0", int'(suspended), 0);
    waitCycles(800);
    check("R5 suspended after continuous idle", int'(suspended), 1);
  endtask

  task automatic testResume();
    int s0 = nSop, r0 = nRes;
    sendK(2); idleJ(2);
    check("R6 resume clears suspended", int'(suspended), 0);
    check("R6 resume pulse", nRes - r0, 1);
    check("R6 resume K is not sop", nSop - s0, 0);
  endtask

  task automatic testWake();
    int d0 = nDrive, r0 = nRes;
    pulseWake(); waitCycles(20);
    check("R7 wake ignored when active", nDrive - d0, 0);
    waitSuspend();
    check("R5 suspended before wake test", int'(suspended), 1);
    waitCycles(500);
    pulseWake(); waitCycles(50);
    check("R7 early wake ignored", nDrive - d0, 0);
    waitCycles(2700);
    check("R7 early request not stored", nDrive - d0, 0);
    pulseWake();
    waitCycles(DRIVE_CYC + 100);
    check("R8 drive length in cycles", nDrive - d0, DRIVE_CYC);
    check("R8 suspended cleared after drive", int'(suspended), 0);
    check("R8 resume pulse after drive", nRes - r0, 1);
  endtask

  task automatic testResetInSuspend();
    int r0 = nRst, q0 = nRes;
    waitSuspend();
    check("R5 suspended again", int'(suspended), 1);
    sendSe0(40); idleJ(2);
    check("R6 SE0 resumes", nRes - q0, 1);
    check("R4 reset seen after resume", nRst - r0, 1);
    check("R6 not suspended after reset", int'(suspended), 0);
  endtask

  initial begin
    repeat (10) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testResetState();
    testClassify();
    testPackets();
    testBusReset();
    testSuspend();
    testResume();
    testWake();
    testResetInSuspend();
    check("R9 no stray wake drive", int'(wakeDrive), 0);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(negedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule